// File: doc/BRIEF.md
# Cacheability Attribute Resolver

This block works out which cache permissions apply to a single memory access. Each cycle it can take one access. An access carries an address, a 3-bit function code, a locked read-modify-write flag, the result of a transparent-translation match with that match's cache-inhibit bit, and a page-descriptor cache-inhibit bit with a valid flag. The block returns an 8-bit attribute byte. Separate bits in that byte allow data caching, data burst fill, instruction caching and instruction burst fill, and one further bit marks that the memory-management stage inhibited caching.

The MMU side is resolved first, and its inhibit wins over everything else. The resolved state starts each access as "enable all" (0xC3). If any inhibit source fires, the state becomes "MMU disable" (0x10). Only when the state is still "enable all" after the MMU stage is it replaced by the hardware attribute of the 64 KB region that holds the address. Those region attributes sit in an internal table that a write port loads. A boot-ROM mode input strips the data permissions from every region attribute as it is read.

Top module: `cache_attr_resolver`

## Requirements
- R1: The attribute byte uses this encoding: bit0 allows data caching, bit1 allows data burst, bit4 marks an MMU inhibit, bit6 allows instruction burst, and bit7 allows instruction caching. For an access presented with `acc_valid` high at one rising edge, `res_valid` is high and `res_attr` holds that access's result for the cycle that follows.
- R2: A locked read-modify-write access always resolves to 0x10.
- R3: When translation applies and `tt_match` is high, the result is 0x10 if `tt_ci` is high. If `tt_ci` is low, the result is the region attribute, and the descriptor inputs are ignored.
- R4: When translation applies and `tt_match` is low, the result is 0x10 if both `desc_valid` and `desc_ci` are high. Otherwise the result is the region attribute.
- R5: Translation applies only when `mmu_enable` is high and `acc_fc` is not 7 (CPU space). If either condition fails, the transparent-translation and descriptor inputs have no effect, and the result is the region attribute.
- R6: The region attribute is the table entry indexed by address bits [16+IDX_W-1:16] (bits [21:16] by default). Address bits above that field do not change the result.
- R7: After reset, `res_valid` is 0, `res_attr` is 0x00, and every table entry holds 0x80 (instruction caching only).
- R8: A table write presented at one rising edge is seen by accesses at later edges. An access to the same region at that same edge still gets the old entry.
- R9: While `boot_rom_mode` is high, bits 0 and 1 of a region-derived result are forced to 0. The stored entries are not changed, so results return to the full entry once the mode is dropped.
- R10: In a cycle with `acc_valid` low, the next cycle has `res_valid` low, and `res_attr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_fc | input | 3 | Function code; 7 is CPU space |
| acc_locked | input | 1 | Access is a locked read-modify-write |
| mmu_enable | input | 1 | Address translation is switched on |
| tt_match | input | 1 | A transparent-translation register matched |
| tt_ci | input | 1 | Cache-inhibit bit of the matching transparent-translation register |
| desc_valid | input | 1 | Page-descriptor fields are valid |
| desc_ci | input | 1 | Page-descriptor cache-inhibit bit |
| boot_rom_mode | input | 1 | Strip data permissions from region attributes |
| tbl_wr_en | input | 1 | Write one region table entry |
| tbl_wr_idx | input | IDX_W | Region index to write |
| tbl_wr_attr | input | 8 | Attribute byte to store |
| res_valid | output | 1 | `res_attr` holds a fresh result |
| res_attr | output | 8 | Resolved attribute byte |

## Verification
Each access result is due exactly one rising edge after the access. The bench drives an access just after a falling edge and reads `res_valid` and `res_attr` at the next falling edge, half a period after the edge that registers them. A table write takes one edge to land. The same-cycle check therefore puts a write and an access to the same region at one edge, expects the old entry, and expects the new entry at the edge after that. Idle hold is checked two falling edges after the last access, so it covers a full cycle with `acc_valid` low.

// File: rtl/cattr_pkg.sv
package cattr_pkg;

    localparam int ATTR_W = 8;

    // attribute byte bits
    localparam logic [ATTR_W-1:0] ATTR_DCACHE  = 8'h01;
    localparam logic [ATTR_W-1:0] ATTR_DBURST  = 8'h02;
    localparam logic [ATTR_W-1:0] ATTR_MMU_INH = 8'h10;
    localparam logic [ATTR_W-1:0] ATTR_IBURST  = 8'h40;
    localparam logic [ATTR_W-1:0] ATTR_ICACHE  = 8'h80;

    localparam logic [ATTR_W-1:0] ATTR_ALL     = ATTR_DCACHE | ATTR_DBURST | ATTR_IBURST | ATTR_ICACHE;
    localparam logic [ATTR_W-1:0] ATTR_MMU_OFF = ATTR_MMU_INH;
    localparam logic [ATTR_W-1:0] ATTR_DATA    = ATTR_DCACHE | ATTR_DBURST;
    localparam logic [ATTR_W-1:0] ATTR_ENTRY_RST = ATTR_ICACHE;

    localparam logic [2:0] FC_CPU_SPACE = 3'd7;

    typedef struct packed {
        logic              vld;
        logic [ATTR_W-1:0] attr;
    } res_t;

endpackage

// File: rtl/cattr_region_table.sv
module cattr_region_table
    import cattr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ATTR_W-1:0] rd_attr
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ATTR_W-1:0] tab_q [DEPTH];
    logic [ATTR_W-1:0] tab_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tab_d[i] = (wr_en && (wr_idx == IDX_W'(i))) ? wr_attr : tab_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= ATTR_ENTRY_RST;
        end else begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= tab_d[i];
        end
    end

    // read returns the stored entry; a write in flight is not forwarded
    assign rd_attr = tab_q[rd_idx];

    AST_TABLE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tab_q[$past(wr_idx)] == $past(wr_attr))); // R8

endmodule

// File: rtl/cattr_mmu_stage.sv
module cattr_mmu_stage
    import cattr_pkg::*;
(
    input  logic              locked,
    input  logic [2:0]        fc,
    input  logic              mmu_en,
    input  logic              tt_hit,
    input  logic              tt_inh,
    input  logic              dsc_vld,
    input  logic              dsc_inh,
    output logic [ATTR_W-1:0] mmu_state
);

    logic translating;

    always_comb begin
        translating = mmu_en && (fc != FC_CPU_SPACE);
        mmu_state   = ATTR_ALL;
        if (locked) begin
            mmu_state = ATTR_MMU_OFF;
        end else if (translating) begin
            if (tt_hit) begin
                if (tt_inh) mmu_state = ATTR_MMU_OFF;
            end else if (dsc_vld && dsc_inh) begin
                mmu_state = ATTR_MMU_OFF;
            end
        end
    end

endmodule

// File: rtl/cattr_merge.sv
module cattr_merge
    import cattr_pkg::*;
(
    input  logic [ATTR_W-1:0] mmu_state,
    input  logic [ATTR_W-1:0] region_attr,
    input  logic              boot_mode,
    output logic [ATTR_W-1:0] final_attr
);

    logic [ATTR_W-1:0] hw_attr;

    always_comb begin
        hw_attr    = boot_mode ? (region_attr & ~ATTR_DATA) : region_attr;
        final_attr = (mmu_state == ATTR_ALL) ? hw_attr : mmu_state;
    end

endmodule

// File: rtl/cache_attr_resolver.sv
module cache_attr_resolver
    import cattr_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int REGION_SHIFT = 16,
    parameter int IDX_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_fc,
    input  logic              acc_locked,
    input  logic              mmu_enable,
    input  logic              tt_match,
    input  logic              tt_ci,
    input  logic              desc_valid,
    input  logic              desc_ci,
    input  logic              boot_rom_mode,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [7:0]        tbl_wr_attr,
    output logic              res_valid,
    output logic [7:0]        res_attr
);

    logic [IDX_W-1:0]  region_idx;
    logic [ATTR_W-1:0] region_attr;
    logic [ATTR_W-1:0] mmu_state;
    logic [ATTR_W-1:0] final_attr;
    res_t              res_d, res_q;

    assign region_idx = acc_addr[REGION_SHIFT +: IDX_W];

    cattr_region_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_attr (tbl_wr_attr),
        .rd_idx  (region_idx),
        .rd_attr (region_attr)
    );

    cattr_mmu_stage u_mmu (
        .locked    (acc_locked),
        .fc        (acc_fc),
        .mmu_en    (mmu_enable),
        .tt_hit    (tt_match),
        .tt_inh    (tt_ci),
        .dsc_vld   (desc_valid),
        .dsc_inh   (desc_ci),
        .mmu_state (mmu_state)
    );

    cattr_merge u_merge (
        .mmu_state   (mmu_state),
        .region_attr (region_attr),
        .boot_mode   (boot_rom_mode),
        .final_attr  (final_attr)
    );

    always_comb begin
        res_d      = res_q;
        res_d.vld  = acc_valid;
        if (acc_valid) res_d.attr = final_attr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_attr  = res_q.attr;

    AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid); // R1
    AST_LOCKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_locked) |=> (res_attr == ATTR_MMU_OFF)); // R2
    AST_TT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_locked && mmu_enable && (acc_fc != FC_CPU_SPACE) && tt_match && tt_ci)
        |=> (res_attr == ATTR_MMU_OFF)); // R3
    AST_DESC_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_locked && mmu_enable && (acc_fc != FC_CPU_SPACE) && !tt_match
         && desc_valid && desc_ci) |=> (res_attr == ATTR_MMU_OFF)); // R4
    AST_BOOT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && boot_rom_mode) |=> (res_attr[1:0] == 2'b00)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!res_valid && $stable(res_attr))); // R10

endmodule

// File: tb/sim_cache_attr_resolver.sv
module sim_cache_attr_resolver;

    localparam int IDX_W = 6;
    localparam int NREG  = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_fc = '0;
    logic        acc_locked = 1'b0;
    logic        mmu_enable = 1'b0;
    logic        tt_match = 1'b0;
    logic        tt_ci = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_ci = 1'b0;
    logic        boot_rom_mode = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [IDX_W-1:0] tbl_wr_idx = '0;
    logic [7:0]  tbl_wr_attr = '0;
    logic        res_valid;
    logic [7:0]  res_attr;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    cache_attr_resolver #(.ADDR_W(32), .REGION_SHIFT(16), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_fc(acc_fc), .acc_locked(acc_locked), .mmu_enable(mmu_enable),
        .tt_match(tt_match), .tt_ci(tt_ci), .desc_valid(desc_valid), .desc_ci(desc_ci),
        .boot_rom_mode(boot_rom_mode), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_attr(tbl_wr_attr), .res_valid(res_valid), .res_attr(res_attr)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] expect_attr(input logic lk, input logic [2:0] fc,
            input logic mm, input logic tt, input logic tci, input logic dv,
            input logic dci, input logic bt, input logic [7:0] ent);
        if (lk) return 8'h10;
        if (mm && fc != 3'd7) begin
            if (tt) begin
                if (tci) return 8'h10;
            end else if (dv && dci) return 8'h10;
        end
        return bt ? (ent & 8'hFC) : ent;
    endfunction

    // called just after a falling edge; returns just after the next one
    task automatic access(input logic [31:0] a, input logic lk, input logic [2:0] fc,
            input logic mm, input logic tt, input logic tci, input logic dv,
            input logic dci, input logic bt, output logic [7:0] got, output logic gv);
        acc_valid = 1'b1; acc_addr = a; acc_locked = lk; acc_fc = fc; mmu_enable = mm;
        tt_match = tt; tt_ci = tci; desc_valid = dv; desc_ci = dci; boot_rom_mode = bt;
        @(negedge clk);
        got = res_attr; gv = res_valid;
        acc_valid = 1'b0;
    endtask

    task automatic table_write(input logic [IDX_W-1:0] idx, input logic [7:0] v);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_attr = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        model[idx] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       gv;
        logic [7:0] held;
        for (int i = 0; i < NREG; i++) model[i] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: output reset state
        check("R7 res_valid", {7'd0, res_valid}, 8'h00);
        check("R7 res_attr", res_attr, 8'h00);

        // R7: every entry starts instruction-only; R5 CPU space bypasses MMU inputs
        for (int r = 0; r < NREG; r++) begin
            access({10'h2A5, 6'(r), 16'h1234}, 1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, got, gv);
            check("R7 entry", got, 8'h80);
            check("R1 res_valid", {7'd0, gv}, 8'h01);
        end
        access(32'h0005_0000, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, got, gv);
        check("R9 reset entry masked", got, 8'h80);

        // load table with distinct patterns
        for (int r = 0; r < NREG; r++) table_write(6'(r), 8'((r * 37 + 5) & 8'hFF));

        // R8: same-edge write and access see the old entry, next access the new
        tbl_wr_en = 1'b1; tbl_wr_idx = 6'd3; tbl_wr_attr = 8'hC3;
        access(32'h0003_0000, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, got, gv);
        tbl_wr_en = 1'b0;
        check("R8 same edge old", got, model[3]);
        model[3] = 8'hC3;
        access(32'h0003_0000, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, got, gv);
        check("R8 next edge new", got, 8'hC3);

        // R6: upper address bits alias onto the same region
        access(32'hFFC3_FFFF, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, got, gv);
        check("R6 alias high", got, model[3]);
        access(32'h0043_0000, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, got, gv);
        check("R6 alias bit22", got, model[3]);

        // full sweep of control inputs
        for (int c = 0; c < 1024; c++) begin
            logic [9:0]  cb;
            logic [5:0]  reg_i;
            logic [31:0] a;
            logic [7:0]  e;
            string       tag;
            cb    = 10'(c);
            reg_i = 6'((c * 7) & 63);
            a     = (32'(c * 40503) << 22) | (32'(reg_i) << 16) | 32'(c & 16'hFFFF);
            e     = expect_attr(cb[0], cb[3:1], cb[4], cb[5], cb[6], cb[7], cb[8], cb[9], model[reg_i]);
            if (cb[0])                          tag = "R2 locked";
            else if (!cb[4] || cb[3:1] == 3'd7) tag = "R5 bypass";
            else if (cb[5])                     tag = "R3 transparent";
            else if (cb[7] && cb[8])            tag = "R4 descriptor";
            else if (cb[9])                     tag = "R9 boot mask";
            else                                tag = "R6 region";
            access(a, cb[0], cb[3:1], cb[4], cb[5], cb[6], cb[7], cb[8], cb[9], got, gv);
            check(tag, got, e);
        end

        // R9: dropping boot mode restores the full entry
        table_write(6'd9, 8'hC3);
        access(32'h0009_0000, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, got, gv);
        check("R9 masked", got, 8'hC0);
        access(32'h0009_0000, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, got, gv);
        check("R9 restored", got, 8'hC3);

        // R10: idle holds the last result
        held = res_attr;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold attr", res_attr, held);
        check("R10 valid low", {7'd0, res_valid}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule